// File: doc/BRIEF.md
# Converter Read-Out Two-Wire Slave

This block is the serial front end of a single-channel 16-bit converter. It watches an oversampled two-wire bus (clock and data lines, both open-drain and idle high), recognises bus start and stop conditions, and compares the first byte after a start with its own 7-bit address. On a match it acknowledges, asks the converter core for a sample, and holds the bus clock low until the result is ready. It then shifts the result out, high byte first. A master that acknowledges the low byte gets a fresh conversion and a new pair of bytes. A master that does not acknowledge ends the read.

The eighth bit of the address byte does not choose a direction, because the block only ever returns data. Instead it is latched and handed to the converter as a flag that keeps the reference powered: 1 keeps it on, 0 asks for shutdown after the read. The block has no registers and no write path.

State machine: `S_IDLE` waits for a start. `S_ADDR` shifts in eight bits, then moves to `S_ADDR_ACK` on a match or back to `S_IDLE` on a mismatch. `S_ADDR_ACK` drives the acknowledge and moves to `S_CONV` after the ninth clock. `S_CONV` stretches the clock until the core reports done, then moves to `S_SETUP`. `S_SETUP` puts the first bit on the data line before the clock is freed, then moves to `S_TX`. `S_TX` shifts out eight bits and moves to `S_TX_ACK`. `S_TX_ACK` reads the master's answer and then moves to `S_TX` for the next byte, to `S_CONV` after the last byte, or to `S_IDLE` on a not-acknowledge. A start from any state goes to `S_ADDR`, and a stop from any state goes to `S_IDLE`.

Top module: `conv_i2c_slave`

## Requirements
- R1: The block acknowledges (pulls data low during the ninth clock) an address byte whose upper seven bits equal binary 011 followed by `addr_strap[3:0]`. Bits are sent MSB first.
- R2: A non-matching address gets no acknowledge and no clock stretch. Every later byte is ignored until the next start.
- R3: The eighth address bit of a matching byte appears on `pwr_keep` after the address phase and holds until the next matching address.
- R4: After the acknowledge clock, `conv_start` pulses for exactly one cycle, and the clock line is held low until `conv_done` has been seen and the first data bit has been set up.
- R5: The result goes out as bits 15..8 and then bits 7..0, MSB first within each byte. A master acknowledge after the high byte leads to the low byte without a new conversion.
- R6: A master acknowledge after the low byte starts a new conversion with a new stretch, followed by the next result pair.
- R7: A master not-acknowledge after any result byte pulses `mst_nack` for one cycle and releases both lines. No further data is driven until a start or stop.
- R8: A start (data falling while clock is high) or a stop (data rising while clock is high) in the middle of a byte abandons the transfer. After a start, a new address phase begins. After a stop, the block waits idle.
- R9: Out of reset both pull-downs are off, `conv_start` and `mst_nack` are low, and `pwr_keep` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample |
| addr_strap | input | 4 | Low four bits of the slave address |
| conv_done | input | 1 | One-cycle pulse from the core: result valid |
| conv_data | input | 16 | Conversion result, valid with `conv_done` |
| sda_pull | output | 1 | Pull the data line low |
| scl_pull | output | 1 | Pull the clock line low (stretch) |
| conv_start | output | 1 | One-cycle request for a conversion |
| pwr_keep | output | 1 | Latched eighth address bit: 1 keeps the reference on |
| mst_nack | output | 1 | One-cycle pulse when the master declines a result byte |

## Verification
The bench targets the cases where a slip would be easiest to miss:
- An address that differs only in its prefix or in its last strap bit. A comparator that ignores either field would acknowledge it.
- A matching address byte clocked after a mismatch without a new start. A slave that does not stay deaf would answer it.
- A start or stop in the middle of a byte. A bit counter that is not cleared would misalign the next address and refuse it, or a slave that does not abort would answer a headless byte.
- Continued reads and an early not-acknowledge after the high byte. Here a wrong byte order, a missing second conversion, or a slave still driving data would each show up as a wrong byte value or a wrong pulse count.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CONV,
        S_SETUP,
        S_TX,
        S_TX_ACK
    } slv_state_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bus_event.sv
module bus_event (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    // clock high on both samples, data moves: bus condition (R8)
    assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave
    import conv_i2c_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          STRAP_W   = 4,
    parameter logic [2:0]  ADDR_PFX  = 3'b011,
    parameter int          SYNC_STG  = 2,
    parameter int          SETUP_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic               sda_pull,
    output logic               scl_pull,
    output logic               conv_start,
    output logic               pwr_keep,
    output logic               mst_nack
);
    localparam int NBYTES = DATA_W / 8;
    localparam int BCW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int SCW    = $clog2(SETUP_CYC + 1);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_ln, syn_ln;
    assign raw_ln = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        line_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_ln[g]), .q(syn_ln[g])
        );
    end

    logic scl_s, sda_s, rise, fall, start_c, stop_c;
    assign scl_s = syn_ln[0];
    assign sda_s = syn_ln[1];

    bus_event u_evt (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(rise), .scl_fall(fall), .start_c(start_c), .stop_c(stop_c)
    );

    // ---------------- state and datapath ----------------
    slv_state_t        st, nxt;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [DATA_W-1:0] res;
    logic [BCW-1:0]    bc;
    logic [SCW-1:0]    scnt;
    logic              ackbit;
    logic              match;

    assign match = (shreg[7:1] == {ADDR_PFX, addr_strap});

    always_comb begin
        nxt = st;
        if (stop_c)       nxt = S_IDLE;
        else if (start_c) nxt = S_ADDR;
        else begin
            unique case (st)
                S_IDLE:     nxt = S_IDLE;
                S_ADDR:     if (fall && cnt == 4'd8) nxt = match ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK: if (fall && cnt == 4'd1) nxt = S_CONV;
                S_CONV:     if (conv_done) nxt = S_SETUP;
                S_SETUP:    if (scnt == '0) nxt = S_TX;
                S_TX:       if (fall && cnt == 4'd7) nxt = S_TX_ACK;
                S_TX_ACK: begin
                    if (fall && cnt == 4'd1) begin
                        if (ackbit)                          nxt = S_IDLE;
                        else if (bc == BCW'(NBYTES - 1))     nxt = S_CONV;
                        else                                 nxt = S_TX;
                    end
                end
                default:    nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            res    <= '0;
            bc     <= '0;
            scnt   <= '0;
            ackbit <= 1'b1;
        end else begin
            st <= nxt;
            unique case (st)
                S_ADDR:     if (rise) begin
                                shreg <= {shreg[6:0], sda_s};
                                cnt   <= cnt + 4'd1;
                            end
                S_ADDR_ACK: if (rise) cnt <= 4'd1;
                S_CONV:     if (conv_done) begin
                                res  <= conv_data;
                                bc   <= '0;
                                scnt <= SCW'(SETUP_CYC - 1);
                            end
                S_SETUP:    if (scnt != '0) scnt <= scnt - 1'b1;
                S_TX:       if (fall) begin
                                res <= res << 1;
                                cnt <= cnt + 4'd1;
                            end
                S_TX_ACK:   if (rise) begin
                                cnt    <= 4'd1;
                                ackbit <= sda_s;
                            end
                default:    ;
            endcase
            if (st == S_TX_ACK && nxt == S_TX) bc <= bc + 1'b1;
            if (nxt != st || start_c || stop_c) cnt <= '0;
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull   <= 1'b0;
            scl_pull   <= 1'b0;
            conv_start <= 1'b0;
            pwr_keep   <= 1'b1;
            mst_nack   <= 1'b0;
        end else begin
            sda_pull   <= (st == S_ADDR_ACK) ||
                          ((st == S_SETUP || st == S_TX) && !res[DATA_W-1]);
            scl_pull   <= (st == S_CONV) || (st == S_SETUP);
            conv_start <= (nxt == S_CONV) && (st != S_CONV);
            mst_nack   <= (st == S_TX_ACK) && rise && sda_s && !start_c && !stop_c;
            if (st == S_ADDR && nxt == S_ADDR_ACK) pwr_keep <= shreg[0];
        end
    end

    // ---------------- assertions ----------------
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r4_stretch_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(conv_start));

    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (st == S_ADDR));

    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> ##1 (!sda_pull && !scl_pull));

    a_r3_flag_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_keep) |-> ($past(st) == S_ADDR));

    a_r2_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> ($past(st) == S_ADDR_ACK || $past(st) == S_SETUP ||
                             $past(st) == S_TX));
endmodule

// File: tb/conv_i2c_slave_tb.sv
module conv_i2c_slave_tb;
    localparam int CONV_LAT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0]  addr_strap = 4'b0000;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        sda_pull, scl_pull, conv_start, pwr_keep, mst_nack;
    wire         scl_line = scl_m & ~scl_pull;
    wire         sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    conv_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .addr_strap(addr_strap), .conv_done(conv_done), .conv_data(conv_data),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .conv_start(conv_start),
        .pwr_keep(pwr_keep), .mst_nack(mst_nack)
    );

    // converter core model and event counters
    logic [15:0] next_res = '0;
    int busy_cnt = -1;
    int n_conv = 0, n_nack = 0, n_stretch = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            busy_cnt <= CONV_LAT;
            n_conv   <= n_conv + 1;
        end else if (busy_cnt == 0) begin
            conv_done <= 1'b1;
            conv_data <= next_res;
            busy_cnt  <= -1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
        if (mst_nack) n_nack <= n_nack + 1;
        if (scl_pull) n_stretch <= n_stretch + 1;
    end

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    int last_wait;
    task automatic clk_bit(input logic b, output logic r);
        sda_m = b;
        tick(4);
        scl_m = 1'b1;
        #1;
        last_wait = 0;
        while (!scl_line) begin tick(1); last_wait++; end
        tick(4);
        r = sda_line;
        tick(4);
        scl_m = 1'b0;
        tick(6);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; #1;
        while (!scl_line) tick(1);
        tick(8); sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(6);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; #1;
        while (!scl_line) tick(1);
        tick(8); sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v, output int first_wait);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
            if (i == 7) first_wait = last_wait;
        end
        clk_bit(!give_ack, r);
    endtask

    // strap[28:25] addr7[24:18] rw[17] data[16:1] exp_ack[0]
    localparam logic [28:0] VEC [7] = '{
        {4'b0111, 7'h37, 1'b1, 16'hA55A, 1'b1},
        {4'b0000, 7'h30, 1'b0, 16'h0001, 1'b1},
        {4'b1111, 7'h3F, 1'b1, 16'hFFFE, 1'b1},
        {4'b1010, 7'h2A, 1'b1, 16'h1111, 1'b0},
        {4'b0101, 7'h35, 1'b0, 16'h8000, 1'b1},
        {4'b0101, 7'h34, 1'b1, 16'h2222, 1'b0},
        {4'b1000, 7'h38, 1'b1, 16'h1234, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] hi, lo, junk;
        int w0, w1, c0, s0, k0;

        // R9: reset state
        tick(3);
        chk(!sda_pull && !scl_pull, "R9 lines released in reset", {sda_pull, scl_pull}, 0);
        chk(!conv_start && !mst_nack, "R9 strobes low in reset", {conv_start, mst_nack}, 0);
        chk(pwr_keep == 1'b1, "R9 pwr_keep reset value", pwr_keep, 1);
        rst_n = 1'b1;
        tick(10);

        // table of transactions: R1 R2 R3 R4 R5 R7
        for (int k = 0; k < 7; k++) begin
            addr_strap = VEC[k][28:25];
            next_res   = VEC[k][16:1];
            c0 = n_conv; s0 = n_stretch; k0 = n_nack;
            bus_start;
            send_byte({VEC[k][24:18], VEC[k][17]}, ack);
            chk(ack == VEC[k][0], "R1 address acknowledge", ack, VEC[k][0]);
            if (VEC[k][0]) begin
                read_byte(1'b1, hi, w0);
                read_byte(1'b0, lo, w1);
                chk(hi == VEC[k][16:9], "R5 high byte first", hi, VEC[k][16:9]);
                chk(lo == VEC[k][8:1], "R5 low byte second", lo, VEC[k][8:1]);
                chk(w0 >= CONV_LAT / 2 && w1 < 3, "R4 stretch only before first byte", w0, CONV_LAT);
                chk(n_conv == c0 + 1, "R4 one conversion request", n_conv - c0, 1);
                chk(pwr_keep == VEC[k][17], "R3 power flag from eighth bit", pwr_keep, VEC[k][17]);
                chk(n_nack == k0 + 1, "R7 nack pulse after low byte", n_nack - k0, 1);
            end else begin
                // R2: a matching byte without a new start must be ignored
                send_byte({3'b011, addr_strap, 1'b1}, ack);
                chk(!ack, "R2 ignored until start", ack, 0);
                chk(n_stretch == s0 && n_conv == c0, "R2 no stretch or request",
                    n_stretch - s0, 0);
            end
            bus_stop;
        end

        // R6: continuous conversions
        addr_strap = 4'b0011;
        next_res = 16'hBEEF;
        c0 = n_conv;
        bus_start;
        send_byte({3'b011, 4'b0011, 1'b1}, ack);
        chk(ack, "R6 address ack", ack, 1);
        read_byte(1'b1, hi, w0);
        next_res = 16'hC0DE;
        read_byte(1'b1, lo, w1);
        chk({hi, lo} == 16'hBEEF, "R6 first result", {hi, lo}, 16'hBEEF);
        read_byte(1'b1, hi, w0);
        read_byte(1'b0, lo, w1);
        chk({hi, lo} == 16'hC0DE, "R6 second result", {hi, lo}, 16'hC0DE);
        chk(w0 >= CONV_LAT / 2, "R6 stretch before second pair", w0, CONV_LAT);
        chk(n_conv == c0 + 2, "R6 two conversions", n_conv - c0, 2);
        bus_stop;

        // R7: nack after high byte releases the bus, then repeated start
        next_res = 16'h5A3C;
        k0 = n_nack;
        bus_start;
        send_byte({3'b011, 4'b0011, 1'b0}, ack);
        read_byte(1'b0, hi, w0);
        chk(hi == 8'h5A, "R7 high byte before nack", hi, 8'h5A);
        chk(n_nack == k0 + 1, "R7 nack pulse", n_nack - k0, 1);
        c0 = n_conv;
        read_byte(1'b0, junk, w0);
        chk(junk == 8'hFF && n_conv == c0, "R7 data released after nack", junk, 8'hFF);
        next_res = 16'h0F0F;
        bus_start;
        send_byte({3'b011, 4'b0011, 1'b1}, ack);
        read_byte(1'b1, hi, w0);
        read_byte(1'b0, lo, w1);
        chk(ack && {hi, lo} == 16'h0F0F, "R8 repeated start read", {hi, lo}, 16'h0F0F);
        chk(pwr_keep == 1'b1, "R3 flag updated on new match", pwr_keep, 1);
        bus_stop;

        // R8: stop in the middle of an address byte
        bus_start;
        begin
            logic r;
            clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
        end
        bus_stop;
        send_byte({3'b011, 4'b0011, 1'b1}, ack);
        chk(!ack, "R8 stop aborts, no headless answer", ack, 0);

        // R8: start in the middle of an address byte restarts the count
        next_res = 16'h7E81;
        bus_start;
        begin
            logic r;
            clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
        end
        bus_start;
        send_byte({3'b011, 4'b0011, 1'b1}, ack);
        chk(ack, "R8 start mid-byte restarts address", ack, 1);
        read_byte(1'b1, hi, w0);
        read_byte(1'b0, lo, w1);
        chk({hi, lo} == 16'h7E81, "R8 read after restart", {hi, lo}, 16'h7E81);
        bus_stop;
        tick(10);
        chk(!sda_pull && !scl_pull, "R7 idle lines released", {sda_pull, scl_pull}, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule